// File: doc/BRIEF.md
# Serial-to-Parallel Port Expander with Strobed Output Latches

This block widens a microcontroller's output port over four wires: serial data, serial clock, a strobe and an active-low clear. On each rising edge of the serial clock, the data bit enters the first stage of a 12-stage shift register and every stage moves one place along. A bank of output latches drives the 12 parallel outputs. The strobe level controls these latches. While the strobe is high the latches hold, so a new word can be shifted in behind outputs that do not change. While the strobe is low the latches copy the register and follow it.

The last stage of the register is brought out as a serial output. A second expander can be chained behind this one and receives the same bit stream 12 serial clocks later. Clear empties only the latches. Shifting and the serial output carry on whatever the strobe and clear are doing.

All four wire inputs are sampled by the system clock through two-flop synchronizers. A serial clock edge is detected from the synchronized value. The serial clock must therefore run slower than a quarter of the system clock, with data held stable around its rising edge.

Top module: `sipo_expander`

## Requirements
- R1: A synchronous, active-high reset sets the shift register, the latches, the parallel outputs and the serial output to all zeros.
- R2: Each rising edge of the serial clock shifts the register by one place. The serial input enters stage 1, which drives `par_o[0]`. Stage k moves to stage k+1, and stage 12 drives `par_o[11]`. After 12 edges, the first bit sent appears on `par_o[11]`.
- R3: While strobe is high and clear is inactive, the parallel outputs keep their values as the register shifts.
- R4: When strobe goes low, the current register contents are copied into the latches and appear on the parallel outputs.
- R5: While strobe stays low with clear inactive, the parallel outputs follow the register after every shift.
- R6: While clear is low, all parallel outputs are 0, whatever the strobe and serial clock are doing.
- R7: Clear does not alter the shift register. Shifting continues during clear, and releasing clear with strobe low shows the register contents as they would be without clear.
- R8: The serial output equals stage 12 and follows every shift, independent of strobe and clear, so a chained device sees the data 12 serial clocks later.
- R9: A falling serial-clock edge, or a data change while the serial clock is steady, does not shift the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock from the controller (asynchronous) |
| sdat_i | input | 1 | Serial data, sampled on the serial clock rising edge |
| stb_i | input | 1 | Strobe: low = latches transparent, high = latches hold |
| clr_n_i | input | 1 | Clear, active low, zeroes the latches only |
| par_o | output | WIDTH (12) | Parallel outputs; bit 0 is stage 1 |
| ser_o | output | 1 | Serial output from stage 12, for chaining |

## Verification
The test words include twelve walking ones, all ones, two alternating patterns and a run of arithmetic words. Walking ones show that each stage lands on the right output pin and in the right order, while the alternating and mixed words expose stuck or swapped stages. Each word is shifted in with strobe high and then exposed by dropping strobe. This separates holding behaviour from copying behaviour. Further passes shift with strobe low, with clear held low, and with clock levels held or falling edges only. Throughout these passes, a bench-side register model predicts the serial output after every bit. These passes tell apart latch following, clear priority, a clear that wrongly empties the register, and false shifting on the wrong edge.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  // Synchronized view of the four wire inputs
  typedef struct packed {
    logic sclk;
    logic sdat;
    logic stb;
    logic clr_n;
  } wire_ctl_t;

  localparam int CTL_BITS = $bits(wire_ctl_t);
  // Idle levels: clock low, data low, strobe high (hold), clear inactive
  localparam wire_ctl_t CTL_IDLE = '{sclk: 1'b0, sdat: 1'b0, stb: 1'b1, clr_n: 1'b1};
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sipo_shifter.sv
module sipo_shifter #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_s,
  input  logic             sdat_s,
  output logic             shift_en,
  output logic [WIDTH-1:0] q
);
  logic sclk_prev;

  // Rising edge of the synchronized serial clock
  assign shift_en = sclk_s & ~sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      q         <= '0;
    end else begin
      sclk_prev <= sclk_s;
      if (shift_en) q <= {q[WIDTH-2:0], sdat_s};
    end
  end
endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb_s,
  input  logic             clr_n_s,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // Clear wins over strobe; strobe low = follow, strobe high = hold
  logic load;
  assign load = ~stb_s;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst || !clr_n_s) q[i] <= 1'b0;
      else if (load)       q[i] <= d[i];
    end
  end
endmodule

// File: rtl/sipo_expander.sv
module sipo_expander
  import sipo_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             sdat_i,
  input  logic             stb_i,
  input  logic             clr_n_i,
  output logic [WIDTH-1:0] par_o,
  output logic             ser_o
);
  wire_ctl_t        ctl_raw;
  wire_ctl_t        ctl_s;
  logic             shift_en;
  logic [WIDTH-1:0] shreg;

  assign ctl_raw = '{sclk: sclk_i, sdat: sdat_i, stb: stb_i, clr_n: clr_n_i};

  sipo_sync #(
    .W(CTL_BITS), .STAGES(SYNC_STAGES), .INIT(CTL_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_s)
  );

  sipo_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .sclk_s(ctl_s.sclk), .sdat_s(ctl_s.sdat),
    .shift_en(shift_en), .q(shreg)
  );

  sipo_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .stb_s(ctl_s.stb), .clr_n_s(ctl_s.clr_n),
    .d(shreg), .q(par_o)
  );

  // Last stage is a flop, so the cascade output is registered
  assign ser_o = shreg[WIDTH-1];
endmodule

// File: rtl/sipo_expander_chk.sv
module sipo_expander_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             stb_s,
  input logic             clr_s,
  input logic             sdat_s,
  input logic             shift_en,
  input logic [WIDTH-1:0] shreg,
  input logic [WIDTH-1:0] par_o,
  input logic             ser_o
);
  // R6
  clear_forces_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> par_o == '0);

  // R3
  strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_s && clr_s) |=> $stable(par_o));

  // R4
  latch_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb_s && clr_s) |=> par_o == $past(shreg));

  // R2
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> shreg == {$past(shreg[WIDTH-2:0]), $past(sdat_s)});

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(shreg));

  // R8
  cascade_tap_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> ser_o == $past(shreg[WIDTH-2]));
endmodule

bind sipo_expander sipo_expander_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .stb_s(ctl_s.stb), .clr_s(ctl_s.clr_n),
  .sdat_s(ctl_s.sdat), .shift_en(shift_en), .shreg(shreg),
  .par_o(par_o), .ser_o(ser_o)
);

// File: tb/sipo_expander_test.sv
module sipo_expander_test;
  localparam int W = 12;
  localparam logic [W-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdat = 1'b0, stb = 1'b1, clr_n = 1'b1;
  logic [W-1:0] par;
  logic ser;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] model = '0;   // bench copy of the shift register

  always #5 clk = ~clk;

  sipo_expander #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdat_i(sdat),
    .stb_i(stb), .clr_n_i(clr_n), .par_o(par), .ser_o(ser)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdat = b;
    tick(4);
    sclk = 1'b1;
    tick(5);
    sclk = 1'b0;
    tick(5);
    model = {model[W-2:0], b};
  endtask

  function automatic logic [W-1:0] pattern(input int i);
    if (i < W)       return W'(1) << i;
    else if (i == W) return ALL;
    else if (i == W+1) return {(W/2){2'b10}};
    else if (i == W+2) return {(W/2){2'b01}};
    else return W'((i * 1237 + 91) % (1 << W));
  endfunction

  initial begin
    #2_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    tick(4);
    rst = 1'b0;
    tick(2);
    // R1: outputs zero after reset, register zero when exposed
    check("R1 par after reset", par, '0);
    check("R1 ser after reset", {{(W-1){1'b0}}, ser}, '0);
    stb = 1'b0;
    tick(6);
    check("R1 register exposed", par, '0);
    stb = 1'b1;
    tick(6);

    // R2/R3/R4/R8: word sweep shifted behind held outputs, then strobed
    held = '0;
    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] w;
      w = pattern(i);
      for (int b = W-1; b >= 0; b--) begin
        send_bit(w[b]);
        check("R3 hold while shifting", par, held);
        check("R8 serial tap", {{(W-1){1'b0}}, ser}, {{(W-1){1'b0}}, model[W-1]});
      end
      stb = 1'b0;
      tick(6);
      check("R2 R4 word on outputs", par, w);
      stb = 1'b1;
      tick(6);
      held = w;
    end

    // R5: strobe low, outputs follow each shift
    stb = 1'b0;
    tick(6);
    for (int k = 0; k < 16; k++) begin
      send_bit(k[0] ^ k[2]);
      check("R5 follow shift", par, model);
    end

    // R6/R7/R8: clear low, shifting continues, outputs zero
    clr_n = 1'b0;
    tick(6);
    check("R6 clear with strobe low", par, '0);
    for (int k = 0; k < 7; k++) begin
      send_bit(k[1]);
      stb = k[0];
      tick(4);
      check("R6 clear zero", par, '0);
      check("R8 tap during clear", {{(W-1){1'b0}}, ser}, {{(W-1){1'b0}}, model[W-1]});
    end
    stb = 1'b0;
    clr_n = 1'b1;
    tick(6);
    check("R7 register kept through clear", par, model);

    // R9: data toggles with clock steady, falling edge only
    sclk = 1'b1;
    tick(8);
    model = par; // the rise above was a real edge; resync model from outputs
    check("R9 rise taken", par, model);
    for (int k = 0; k < 4; k++) begin
      sdat = ~sdat;
      tick(6);
      check("R9 no shift at high clock", par, model);
    end
    sclk = 1'b0;
    tick(6);
    check("R9 falling edge ignored", par, model);
    for (int k = 0; k < 4; k++) begin
      sdat = ~sdat;
      tick(6);
      check("R9 no shift at low clock", par, model);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule